// File: doc/BRIEF.md
# Protected Cross-Module Call and Return Sequencer

This block steps a processor through a guarded transfer of control between software modules. A call command carries the address of the call instruction, a 16-bit immediate, a register value and the current frame pointer. From these the sequencer builds a target address inside the trampoline region. It saves the frame pointer and the call address on the control stack, then fetches the target word. The target must be an entry instruction. If it is, the caller's module identifier and capability word go onto the stack, the new context is installed and execution is redirected past the entry word. If it is not, the unit traps.

A return command reverses the sequence over several cycles. It first pops and restores the capability word and the module identifier. It then selects the caller's address space and pops the call address. Next it fetches the original call instruction a second time, which may take any number of cycles. That instruction must again be a call. The register field it names tells the unit where the popped frame pointer is written. During the whole sequence a busy flag holds off instruction issue.

Top module: `xmod_call_seq`

## Requirements
- R1: During a call, the fetch address is {TRAMP_W ones, register value bits [MID_W-1:0], immediate}. This equals the register shifted left by IMM_W with the top TRAMP_W bits forced to one. The new module identifier is register bits [MID_W-1:0].
- R2: A call pushes the frame pointer in its first busy cycle and the call-instruction address in its second busy cycle. Push and pop are never active together.
- R3: If the fetched call target has an opcode (bits [31:24]) other than 8'hE5, the unit raises trap_valid for one cycle with trap_code 1. It makes no further push, and cur_mid and cur_caps keep their values.
- R4: A valid entry word pushes the caller's module identifier (zero-extended), then the caller's capability word. After that cur_mid becomes the new identifier and cur_caps becomes entry bits [CAP_W-1:0]. A one-cycle redirect goes to target + 4.
- R5: A return pops the capability word, then the module identifier, restoring each into cur_caps and cur_mid. It then sets fetch_space to the restored identifier, pops the call address and fetches the word at that address.
- R6: fetch_req and fetch_addr stay steady until fetch_rsp_valid. The sequence continues on the cycle after the response, whatever the latency.
- R7: If the refetched word on return has an opcode other than 8'hC4, the unit traps with trap_code 2. It writes no register and the frame pointer stays on the stack.
- R8: On a good return, the unit pops the frame pointer and writes it to the register whose index is the refetched word's bits [20:16]. In the same cycle it redirects to call address + 4.
- R9: busy is high from the cycle after a command is taken until the sequence ends: fetch latency + 5 cycles for a good call, + 4 for a bad call, + 6 for any return. Commands that arrive while busy are ignored.
- R10: After reset, busy, trap_valid, push_valid, pop_valid, fetch_req, rf_we and redirect_valid are low, and cur_mid and cur_caps are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered; taken only when not busy |
| cmd_ret | input | 1 | 0 = call, 1 = return |
| cmd_pc | input | ADDR_W | Address of the call instruction |
| cmd_imm | input | IMM_W | Call immediate (target low bits) |
| cmd_reg | input | ADDR_W | Register value holding the target module identifier |
| cmd_fp | input | ADDR_W | Current frame pointer value |
| busy | output | 1 | Sequence in progress; blocks issue |
| fetch_req | output | 1 | Instruction fetch request |
| fetch_addr | output | ADDR_W | Fetch address |
| fetch_space | output | MID_W | Address space selected for fetch |
| fetch_rsp_valid | input | 1 | Fetched word available |
| fetch_rsp_instr | input | INSTR_W | Fetched word |
| push_valid | output | 1 | Push one word to the control stack |
| push_data | output | ADDR_W | Word pushed |
| pop_valid | output | 1 | Pop the top word of the control stack |
| pop_data | input | ADDR_W | Current top of the control stack |
| rf_we | output | 1 | Register file write |
| rf_waddr | output | RIDX_W | Register index written |
| rf_wdata | output | ADDR_W | Register data written |
| redirect_valid | output | 1 | Resume issue at redirect_pc |
| redirect_pc | output | ADDR_W | Resume address |
| trap_valid | output | 1 | Trap pulse |
| trap_code | output | 2 | 1 = bad entry, 2 = bad return |
| cur_mid | output | MID_W | Current module identifier |
| cur_caps | output | CAP_W | Current capability word |

## Verification
The properties assume that fetch_rsp_valid is raised only while fetch_req is high. They also assume that pop_data presents the current top of the stack in the cycle a pop is requested, and that the stack is never popped empty. The bench meets these assumptions as follows. Its fetch responder answers only a pending request, after a chosen latency. Its stack model applies each push or pop one half-cycle after it sees it. Every return it issues is paired with earlier pushes from the model's own stack. After each trap it discards the words the aborted sequence left behind, so the next return finds a well-formed frame.

// File: rtl/xmod_pkg.sv
`timescale 1ns/1ps
// Shared types and opcode values for the cross-module call sequencer.
// Assumes an 8-bit opcode in the top byte of every instruction word.
package xmod_pkg;

    localparam int unsigned OPC_W = 8;
    localparam logic [OPC_W-1:0] OPC_CALL  = 8'hC4;
    localparam logic [OPC_W-1:0] OPC_ENTRY = 8'hE5;

    typedef enum logic [1:0] {
        TRAP_NONE       = 2'd0,
        TRAP_BAD_ENTRY  = 2'd1,
        TRAP_BAD_RETURN = 2'd2
    } trap_code_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_C_PUSH_FP,
        S_C_PUSH_PC,
        S_C_FETCH,
        S_E_PUSH_MID,
        S_E_PUSH_CAPS,
        S_R_POP_CAPS,
        S_R_POP_MID,
        S_R_SPACE,
        S_R_POP_PC,
        S_R_FETCH,
        S_R_POP_FP,
        S_TRAP
    } seq_state_e;

endpackage

// File: rtl/xmod_target_gen.sv
`timescale 1ns/1ps
// Forms the trampoline target of a call from the immediate and a register.
// The register is shifted above the immediate and the top TRAMP_W bits are
// forced to TRAMP_PREFIX. Assumes ADDR_W == TRAMP_W + MID_W + IMM_W.
module xmod_target_gen #(
    parameter int unsigned MID_W   = 12,
    parameter int unsigned IMM_W   = 16,
    parameter int unsigned TRAMP_W = 4,
    parameter logic [TRAMP_W-1:0] TRAMP_PREFIX = {TRAMP_W{1'b1}},
    localparam int unsigned ADDR_W = TRAMP_W + MID_W + IMM_W
) (
    input  logic [ADDR_W-1:0] reg_val,
    input  logic [IMM_W-1:0]  imm,
    output logic [ADDR_W-1:0] target,
    output logic [MID_W-1:0]  new_mid
);

    localparam int unsigned KEEP_MSB = ADDR_W - TRAMP_W - 1;

    logic [ADDR_W-1:0] shifted;
    logic [ADDR_W-1:0] merged;
    logic              unused_hi;

    // Place the register above the immediate field.
    always_comb begin
        shifted = reg_val << IMM_W;
        merged  = shifted | {{(ADDR_W-IMM_W){1'b0}}, imm};
    end

    // Force the trampoline region and extract the new module identifier.
    assign target    = {TRAMP_PREFIX, merged[KEEP_MSB:0]};
    assign new_mid   = reg_val[MID_W-1:0];
    assign unused_hi = ^{merged[ADDR_W-1:KEEP_MSB+1], reg_val[ADDR_W-1:MID_W]};

endmodule

// File: rtl/xmod_opcode_chk.sv
`timescale 1ns/1ps
// Decodes a fetched word: call / entry opcode match, the frame-pointer
// register index of a call word and the capability field of an entry word.
// Assumes INSTR_W >= OPC_W + CAP_W + RIDX_W.
module xmod_opcode_chk
    import xmod_pkg::*;
#(
    parameter int unsigned INSTR_W = 32,
    parameter int unsigned CAP_W   = 16,
    parameter int unsigned RIDX_W  = 5
) (
    input  logic [INSTR_W-1:0] instr,
    output logic               is_call,
    output logic               is_entry,
    output logic [RIDX_W-1:0]  fp_idx,
    output logic [CAP_W-1:0]   caps
);

    localparam int unsigned OPC_LSB = INSTR_W - OPC_W;
    localparam int unsigned FP_LSB  = CAP_W;
    localparam int unsigned FP_MSB  = CAP_W + RIDX_W - 1;

    logic [OPC_W-1:0] opc;
    logic             unused_gap;

    // Split the word into its fields.
    always_comb begin
        opc      = instr[INSTR_W-1:OPC_LSB];
        is_call  = (opc == OPC_CALL);
        is_entry = (opc == OPC_ENTRY);
        fp_idx   = instr[FP_MSB:FP_LSB];
        caps     = instr[CAP_W-1:0];
    end

    assign unused_gap = ^instr[OPC_LSB-1:FP_MSB+1];

endmodule

// File: rtl/xmod_ctx_regs.sv
`timescale 1ns/1ps
// Holds the current module identifier and capability word. Each has its own
// load strobe because a return restores them on different cycles.
module xmod_ctx_regs #(
    parameter int unsigned MID_W = 12,
    parameter int unsigned CAP_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mid_we,
    input  logic [MID_W-1:0] mid_d,
    input  logic             caps_we,
    input  logic [CAP_W-1:0] caps_d,
    output logic [MID_W-1:0] mid_q,
    output logic [CAP_W-1:0] caps_q
);

    // Module identifier register.
    always_ff @(posedge clk) begin
        if (!rst_n)      mid_q <= '0;
        else if (mid_we) mid_q <= mid_d;
    end

    // Capability register.
    always_ff @(posedge clk) begin
        if (!rst_n)       caps_q <= '0;
        else if (caps_we) caps_q <= caps_d;
    end

endmodule

// File: rtl/xmod_call_seq.sv
`timescale 1ns/1ps
// Sequencer for protected cross-module call, entry check and return.
// Call: push FP, push call address, fetch trampoline target, require entry
// opcode, push caller MID and caps, install new context, redirect.
// Return: pop caps, pop MID, select caller space, pop call address, refetch
// the call word, require call opcode, pop FP into the register it names.
// Assumes pop_data shows the stack top in the cycle pop_valid is high and
// fetch_rsp_valid is only raised while fetch_req is high.
module xmod_call_seq
    import xmod_pkg::*;
#(
    parameter int unsigned MID_W   = 12,
    parameter int unsigned IMM_W   = 16,
    parameter int unsigned TRAMP_W = 4,
    parameter logic [TRAMP_W-1:0] TRAMP_PREFIX = {TRAMP_W{1'b1}},
    parameter int unsigned CAP_W   = 16,
    parameter int unsigned RIDX_W  = 5,
    parameter int unsigned INSTR_W = 32,
    localparam int unsigned ADDR_W = TRAMP_W + MID_W + IMM_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic               cmd_ret,
    input  logic [ADDR_W-1:0]  cmd_pc,
    input  logic [IMM_W-1:0]   cmd_imm,
    input  logic [ADDR_W-1:0]  cmd_reg,
    input  logic [ADDR_W-1:0]  cmd_fp,
    output logic               busy,
    output logic               fetch_req,
    output logic [ADDR_W-1:0]  fetch_addr,
    output logic [MID_W-1:0]   fetch_space,
    input  logic               fetch_rsp_valid,
    input  logic [INSTR_W-1:0] fetch_rsp_instr,
    output logic               push_valid,
    output logic [ADDR_W-1:0]  push_data,
    output logic               pop_valid,
    input  logic [ADDR_W-1:0]  pop_data,
    output logic               rf_we,
    output logic [RIDX_W-1:0]  rf_waddr,
    output logic [ADDR_W-1:0]  rf_wdata,
    output logic               redirect_valid,
    output logic [ADDR_W-1:0]  redirect_pc,
    output logic               trap_valid,
    output logic [1:0]         trap_code,
    output logic [MID_W-1:0]   cur_mid,
    output logic [CAP_W-1:0]   cur_caps
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

    seq_state_e        st_q, st_d;
    logic [ADDR_W-1:0] pc_q, fp_q, tgt_q;
    logic [MID_W-1:0]  nmid_q, space_q;
    logic [CAP_W-1:0]  ecaps_q;
    logic [RIDX_W-1:0] fpidx_q;
    trap_code_e        tcode_q;

    logic [ADDR_W-1:0] tgt_w;
    logic [MID_W-1:0]  nmid_w;
    logic              dec_call, dec_entry;
    logic [RIDX_W-1:0] dec_fp;
    logic [CAP_W-1:0]  dec_caps;
    logic              cmd_take, fetch_take;
    logic              mid_we, caps_we;
    logic [MID_W-1:0]  mid_d;
    logic [CAP_W-1:0]  caps_d;

    xmod_target_gen #(
        .MID_W(MID_W), .IMM_W(IMM_W), .TRAMP_W(TRAMP_W), .TRAMP_PREFIX(TRAMP_PREFIX)
    ) u_tgen (
        .reg_val(cmd_reg), .imm(cmd_imm), .target(tgt_w), .new_mid(nmid_w)
    );

    xmod_opcode_chk #(
        .INSTR_W(INSTR_W), .CAP_W(CAP_W), .RIDX_W(RIDX_W)
    ) u_dec (
        .instr(fetch_rsp_instr), .is_call(dec_call), .is_entry(dec_entry),
        .fp_idx(dec_fp), .caps(dec_caps)
    );

    xmod_ctx_regs #(
        .MID_W(MID_W), .CAP_W(CAP_W)
    ) u_ctx (
        .clk(clk), .rst_n(rst_n), .mid_we(mid_we), .mid_d(mid_d),
        .caps_we(caps_we), .caps_d(caps_d), .mid_q(cur_mid), .caps_q(cur_caps)
    );

    assign cmd_take   = (st_q == S_IDLE) && cmd_valid;
    assign fetch_take = fetch_req && fetch_rsp_valid;
    assign busy       = (st_q != S_IDLE);

    // Next-state selection.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE:        if (cmd_take) st_d = cmd_ret ? S_R_POP_CAPS : S_C_PUSH_FP;
            S_C_PUSH_FP:   st_d = S_C_PUSH_PC;
            S_C_PUSH_PC:   st_d = S_C_FETCH;
            S_C_FETCH:     if (fetch_take) st_d = dec_entry ? S_E_PUSH_MID : S_TRAP;
            S_E_PUSH_MID:  st_d = S_E_PUSH_CAPS;
            S_E_PUSH_CAPS: st_d = S_IDLE;
            S_R_POP_CAPS:  st_d = S_R_POP_MID;
            S_R_POP_MID:   st_d = S_R_SPACE;
            S_R_SPACE:     st_d = S_R_POP_PC;
            S_R_POP_PC:    st_d = S_R_FETCH;
            S_R_FETCH:     if (fetch_take) st_d = dec_call ? S_R_POP_FP : S_TRAP;
            S_R_POP_FP:    st_d = S_IDLE;
            S_TRAP:        st_d = S_IDLE;
            default:       st_d = S_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    // Capture command operands and the call target on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fp_q   <= '0;
            tgt_q  <= '0;
            nmid_q <= '0;
        end else if (cmd_take) begin
            fp_q <= cmd_fp;
            if (!cmd_ret) begin
                tgt_q  <= tgt_w;
                nmid_q <= nmid_w;
            end
        end
    end

    // Call address: from the command, or popped during a return.
    always_ff @(posedge clk) begin
        if (!rst_n)                 pc_q <= '0;
        else if (cmd_take)          pc_q <= cmd_pc;
        else if (st_q == S_R_POP_PC) pc_q <= pop_data;
    end

    // Address space select: target module on call, restored caller on return.
    always_ff @(posedge clk) begin
        if (!rst_n)                     space_q <= '0;
        else if (cmd_take && !cmd_ret)  space_q <= nmid_w;
        else if (st_q == S_R_SPACE)     space_q <= cur_mid;
    end

    // Latch decoded fields of accepted fetch responses and the trap cause.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ecaps_q <= '0;
            fpidx_q <= '0;
            tcode_q <= TRAP_NONE;
        end else if (fetch_take) begin
            if (st_q == S_C_FETCH) begin
                ecaps_q <= dec_caps;
                tcode_q <= TRAP_BAD_ENTRY;
            end else begin
                fpidx_q <= dec_fp;
                tcode_q <= TRAP_BAD_RETURN;
            end
        end
    end

    // Context register load strobes and sources.
    always_comb begin
        mid_we  = (st_q == S_E_PUSH_CAPS) || (st_q == S_R_POP_MID);
        caps_we = (st_q == S_E_PUSH_CAPS) || (st_q == S_R_POP_CAPS);
        mid_d   = (st_q == S_E_PUSH_CAPS) ? nmid_q  : pop_data[MID_W-1:0];
        caps_d  = (st_q == S_E_PUSH_CAPS) ? ecaps_q : pop_data[CAP_W-1:0];
    end

    // Port outputs decoded from the current state.
    always_comb begin
        fetch_req      = (st_q == S_C_FETCH) || (st_q == S_R_FETCH);
        fetch_addr     = (st_q == S_R_FETCH) ? pc_q : tgt_q;
        fetch_space    = space_q;
        push_valid     = 1'b0;
        push_data      = '0;
        pop_valid      = (st_q == S_R_POP_CAPS) || (st_q == S_R_POP_MID) ||
                         (st_q == S_R_POP_PC)   || (st_q == S_R_POP_FP);
        rf_we          = (st_q == S_R_POP_FP);
        rf_waddr       = fpidx_q;
        rf_wdata       = pop_data;
        redirect_valid = 1'b0;
        redirect_pc    = '0;
        trap_valid     = (st_q == S_TRAP);
        trap_code      = (st_q == S_TRAP) ? tcode_q : TRAP_NONE;
        unique case (st_q)
            S_C_PUSH_FP: begin
                push_valid = 1'b1;
                push_data  = fp_q;
            end
            S_C_PUSH_PC: begin
                push_valid = 1'b1;
                push_data  = pc_q;
            end
            S_E_PUSH_MID: begin
                push_valid = 1'b1;
                push_data  = {{(ADDR_W-MID_W){1'b0}}, cur_mid};
            end
            S_E_PUSH_CAPS: begin
                push_valid     = 1'b1;
                push_data      = {{(ADDR_W-CAP_W){1'b0}}, cur_caps};
                redirect_valid = 1'b1;
                redirect_pc    = tgt_q + STEP;
            end
            S_R_POP_FP: begin
                redirect_valid = 1'b1;
                redirect_pc    = pc_q + STEP;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/xmod_call_seq_chk.sv
`timescale 1ns/1ps
// Protocol checker for the call sequencer, bound to every instance.
// Assumes the environment only answers a pending fetch request.
module xmod_call_seq_chk #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned MID_W  = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              busy,
    input logic              fetch_req,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic              fetch_rsp_valid,
    input logic              push_valid,
    input logic              pop_valid,
    input logic              rf_we,
    input logic              redirect_valid,
    input logic              trap_valid,
    input logic [1:0]        trap_code,
    input logic [MID_W-1:0]  cur_mid
);

    a_r6_fetch_held: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req && !fetch_rsp_valid |=> fetch_req && $stable(fetch_addr));

    a_r2_stack_excl: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid |-> !pop_valid);

    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(push_valid || pop_valid || fetch_req || rf_we || redirect_valid || trap_valid));

    a_r9_cmd_starts: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && cmd_valid |=> busy);

    a_r3_trap_ends: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |=> !busy);

    a_r7_trap_clean: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |-> !rf_we && !redirect_valid && (trap_code != 2'd0));

    a_r8_rf_with_pop: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> redirect_valid && pop_valid);

    a_r4_mid_moves: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_mid) |-> $past(redirect_valid || pop_valid));

endmodule

bind xmod_call_seq xmod_call_seq_chk #(.ADDR_W(ADDR_W), .MID_W(MID_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .busy(busy),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_rsp_valid(fetch_rsp_valid),
    .push_valid(push_valid), .pop_valid(pop_valid), .rf_we(rf_we),
    .redirect_valid(redirect_valid), .trap_valid(trap_valid),
    .trap_code(trap_code), .cur_mid(cur_mid)
);

// File: tb/xmod_call_seq_bench.sv
`timescale 1ns/1ps
// Bench: behavioural stack/fetch environment plus a queue-based model of the
// expected port traffic, compared on every clock.
module xmod_call_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0, cmd_ret = 1'b0;
    logic [31:0] cmd_pc = '0, cmd_reg = '0, cmd_fp = '0;
    logic [15:0] cmd_imm = '0;
    logic        busy, fetch_req, push_valid, pop_valid, rf_we, redirect_valid, trap_valid;
    logic [31:0] fetch_addr, push_data, rf_wdata, redirect_pc;
    logic [11:0] fetch_space, cur_mid;
    logic [15:0] cur_caps;
    logic [4:0]  rf_waddr;
    logic [1:0]  trap_code;
    logic        fetch_rsp_valid = 1'b0;
    logic [31:0] fetch_word = '0;
    logic [31:0] pop_data = '0;

    xmod_call_seq u_xmod_call_seq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ret(cmd_ret),
        .cmd_pc(cmd_pc), .cmd_imm(cmd_imm), .cmd_reg(cmd_reg), .cmd_fp(cmd_fp),
        .busy(busy), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .fetch_space(fetch_space), .fetch_rsp_valid(fetch_rsp_valid),
        .fetch_rsp_instr(fetch_word), .push_valid(push_valid), .push_data(push_data),
        .pop_valid(pop_valid), .pop_data(pop_data), .rf_we(rf_we), .rf_waddr(rf_waddr),
        .rf_wdata(rf_wdata), .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
        .trap_valid(trap_valid), .trap_code(trap_code), .cur_mid(cur_mid), .cur_caps(cur_caps)
    );

    always #2.5 clk = ~clk;

    int n_tests = 0, n_fail = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Environment and model state.
    logic [31:0] dstack[$];
    logic [31:0] mstack[$];
    logic [31:0] exp_push[$];
    logic [31:0] exp_rf_data[$];
    int          exp_rf_idx[$];
    logic [31:0] exp_redir[$];
    int          exp_trap[$];
    logic [31:0] exp_faddr = '0;
    logic [11:0] exp_fspace = '0;
    logic [11:0] m_mid = '0;
    logic [15:0] m_caps = '0;
    int          exp_busy = 0, exp_pops = 0, busy_cnt = 0, pop_cnt = 0;
    int          flat = 0, fcnt = 0;
    bit          pend_push = 0, pend_pop = 0;
    logic [31:0] pend_data = '0;
    logic [31:0] mon_e = '0;
    int          mon_i = 0;

    // Stack, fetch responder and per-clock comparison against the model.
    always @(negedge clk) begin
        if (pend_push) dstack.push_back(pend_data);
        if (pend_pop && dstack.size() > 0) void'(dstack.pop_back());
        pend_push = 0;
        pend_pop  = 0;
        pop_data  = (dstack.size() > 0) ? dstack[$] : 32'h0;
        if (rst_n) begin
            if (busy) busy_cnt++;
            if (push_valid) begin
                pend_push = 1;
                pend_data = push_data;
                if (exp_push.size() > 0) begin
                    mon_e = exp_push.pop_front();
                    check(push_data == mon_e, "R2/R4", "push data", push_data, mon_e);
                end else check(0, "R3", "unexpected push", push_data, 32'h0);
            end
            if (pop_valid) begin
                pend_pop = 1;
                pop_cnt++;
            end
            if (rf_we) begin
                if (exp_rf_data.size() > 0) begin
                    mon_e = exp_rf_data.pop_front();
                    mon_i = exp_rf_idx.pop_front();
                    check(rf_wdata == mon_e, "R8", "fp value", rf_wdata, mon_e);
                    check(int'(rf_waddr) == mon_i, "R8", "fp reg", 32'(rf_waddr), 32'(mon_i));
                end else check(0, "R7", "unexpected rf write", rf_wdata, 32'h0);
            end
            if (redirect_valid) begin
                if (exp_redir.size() > 0) begin
                    mon_e = exp_redir.pop_front();
                    check(redirect_pc == mon_e, "R4/R8", "redirect", redirect_pc, mon_e);
                end else check(0, "R3/R7", "unexpected redirect", redirect_pc, 32'h0);
            end
            if (trap_valid) begin
                if (exp_trap.size() > 0) begin
                    mon_i = exp_trap.pop_front();
                    check(int'(trap_code) == mon_i, "R3/R7", "trap code", 32'(trap_code), 32'(mon_i));
                end else check(0, "R3/R7", "unexpected trap", 32'(trap_code), 32'h0);
            end
            if (fetch_req) begin
                if (fcnt == flat) begin
                    fetch_rsp_valid = 1'b1;
                    check(fetch_addr == exp_faddr, "R1/R5", "fetch addr", fetch_addr, exp_faddr);
                    check(fetch_space == exp_fspace, "R1/R5", "fetch space", 32'(fetch_space), 32'(exp_fspace));
                end else fetch_rsp_valid = 1'b0;
                fcnt++;
            end else begin
                fetch_rsp_valid = 1'b0;
                fcnt = 0;
            end
        end
    end

    // Drive the prepared command, wait for the end, compare model and ports.
    task automatic run(input bit ret, input bit poke, input string req);
        bit done = 0;
        busy_cnt = 0;
        pop_cnt  = 0;
        @(negedge clk);
        cmd_ret   = ret;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int c = 0; c < 400; c++) begin
            if (!busy) begin done = 1; break; end
            @(negedge clk);
            if (poke && c == 1) begin cmd_valid = 1'b1; cmd_ret = ~ret; end
            if (poke && c == 3) cmd_valid = 1'b0;
        end
        check(done, "R9", "sequence ended", 32'(done), 32'h1);
        #1;
        check(busy_cnt == exp_busy, req, "busy cycles", 32'(busy_cnt), 32'(exp_busy));
        check(pop_cnt == exp_pops, req, "pop count", 32'(pop_cnt), 32'(exp_pops));
        check(exp_push.size() == 0 && exp_redir.size() == 0 && exp_trap.size() == 0
              && exp_rf_data.size() == 0, req, "missing events",
              32'(exp_push.size() + exp_redir.size() + exp_trap.size() + exp_rf_data.size()), 32'h0);
        check(cur_mid == m_mid, req, "cur_mid", 32'(cur_mid), 32'(m_mid));
        check(cur_caps == m_caps, req, "cur_caps", 32'(cur_caps), 32'(m_caps));
        check(dstack.size() == mstack.size(), req, "stack depth", 32'(dstack.size()), 32'(mstack.size()));
        for (int k = 0; k < mstack.size() && k < dstack.size(); k++)
            check(dstack[k] == mstack[k], req, "stack word", dstack[k], mstack[k]);
        @(negedge clk);
        check(!busy, "R9", "stays idle", 32'(busy), 32'h0);
    endtask

    // Model of a call per R1..R4.
    task automatic do_call(input logic [31:0] pc, input logic [15:0] imm, input logic [31:0] rv,
                           input logic [31:0] fp, input logic [31:0] word, input int lat,
                           input bit poke);
        logic [31:0] tgt;
        tgt = {4'hF, rv[11:0], imm};
        cmd_pc = pc; cmd_imm = imm; cmd_reg = rv; cmd_fp = fp;
        fetch_word = word; flat = lat;
        exp_faddr = tgt; exp_fspace = rv[11:0];
        exp_push.push_back(fp); exp_push.push_back(pc);
        mstack.push_back(fp); mstack.push_back(pc);
        exp_pops = 0;
        if (word[31:24] == 8'hE5) begin
            exp_push.push_back({20'h0, m_mid});
            exp_push.push_back({16'h0, m_caps});
            mstack.push_back({20'h0, m_mid});
            mstack.push_back({16'h0, m_caps});
            m_mid = rv[11:0];
            m_caps = word[15:0];
            exp_redir.push_back(tgt + 32'd4);
            exp_busy = lat + 5;
            run(1'b0, poke, "R4");
        end else begin
            exp_trap.push_back(1);
            exp_busy = lat + 4;
            run(1'b0, poke, "R3");
        end
    endtask

    // Model of a return per R5..R8.
    task automatic do_ret(input logic [31:0] word, input int lat);
        logic [31:0] pc, fp, cw, mw;
        fetch_word = word; flat = lat;
        cw = mstack.pop_back();
        mw = mstack.pop_back();
        pc = mstack.pop_back();
        m_caps = cw[15:0];
        m_mid = mw[11:0];
        exp_faddr = pc; exp_fspace = m_mid;
        exp_busy = lat + 6;
        if (word[31:24] == 8'hC4) begin
            fp = mstack.pop_back();
            exp_rf_idx.push_back(int'(word[20:16]));
            exp_rf_data.push_back(fp);
            exp_redir.push_back(pc + 32'd4);
            exp_pops = 4;
            run(1'b1, 1'b0, "R5");
        end else begin
            exp_trap.push_back(2);
            exp_pops = 3;
            run(1'b1, 1'b0, "R7");
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R10: state held in reset.
        check(!busy && !trap_valid && !push_valid && !pop_valid && !fetch_req && !rf_we
              && !redirect_valid, "R10", "reset outputs", 32'(busy), 32'h0);
        check(cur_mid == 12'h0 && cur_caps == 16'h0, "R10", "reset context",
              {cur_mid, 4'h0, cur_caps}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1/R4: call with junk above the identifier field, no fetch delay.
        do_call(32'h0000_0100, 16'h4000, 32'hABCD_0123, 32'h1111_0000, 32'hE500_A55A, 0, 0);
        // R6/R9: nested call, delayed fetch, stray command while busy.
        do_call(32'h0200_0040, 16'h0010, 32'h0000_0456, 32'h2222_0000, 32'hE500_0F0F, 3, 1);
        // R5/R6/R8: return from the inner call with a long refetch.
        do_ret({8'hC4, 3'b000, 5'd7, 16'h0010}, 5);
        // R5/R8: return to the outermost context.
        do_ret({8'hC4, 3'b000, 5'd29, 16'h4000}, 0);

        // R3: target is not an entry word; FP and call address remain stacked.
        do_call(32'h0000_0300, 16'h0020, 32'h0000_0789, 32'h3333_0000, 32'h0000_1234, 2, 0);
        repeat (2) begin void'(mstack.pop_back()); void'(dstack.pop_back()); end
        check(dstack.size() == 0, "R3", "stack after cleanup", 32'(dstack.size()), 32'h0);

        // R7: good call, then refetch returns a non-call opcode.
        do_call(32'h0000_0500, 16'h0030, 32'h0000_00AA, 32'h4444_0000, 32'hE500_00C3, 1, 0);
        do_ret({8'hE5, 3'b000, 5'd3, 16'h0030}, 4);
        check(dstack.size() == 1 && dstack[0] == 32'h4444_0000, "R7", "fp left on stack",
              dstack.size() > 0 ? dstack[0] : 32'h0, 32'h4444_0000);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL R9 watchdog: actual %h expected %h", 32'h1, 32'h0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule